// File: doc/BRIEF.md
# Nibble-Wide Display RAM Host Port

This block lets a host processor reach a display memory, and a small bank of configuration registers, through a narrow 4-bit bus. The host first drives the select line low and presents three address nibbles, most significant first, each one taken on a write strobe. Raising the select line switches the port to data transfers. Each data nibble that is written or read then uses the current address, and an internal counter advances the address after the nibble. Long runs of display data can therefore be streamed after a single address setup.

The internal array holds the display image. Each row takes 32 consecutive nibble addresses, so a row starts at a multiple of 32, and the array spans 80 rows. The three addresses just above the array are configuration registers. Their bits leave the block as static settings for the bias and regulator circuits: a resistor-select flag, a divider ratio code, a 6-bit level code and a power-source selection. Strobes are asynchronous to the block clock, so they pass through a synchroniser, and their edges are detected on the block clock.

Top module: `nibram_host_port`

## Requirements
- R1: After reset the configuration outputs are rsel=0, ratio=3'b010, level=6'b000000 and psrc=2'b00, and the read bus is not driven.
- R2: While sel_data is low, successive write strobes load address bits 11:8, then 7:4, then 3:0.
- R3: The address nibble sequence restarts at bits 11:8 whenever sel_data falls or en_n is high.
- R4: While sel_data is high, a write strobe stores din at the current address, and the address then increments by one.
- R5: While sel_data is high, dout presents the nibble at the current address while the read strobe is high, and the address increments when the strobe ends.
- R6: While en_n is high, write and read strobes change neither memory, registers nor the address.
- R7: dout_oe is high only while rd_stb is high and en_n is low.
- R8: Address DISP_WORDS (2560) drives rsel from bit 3 and ratio from bits 2:0. Address 2561 drives level bits 3:0. Address 2562 drives level bits 5:4 from its bits 1:0 and psrc from its bits 3:2. All three read back as written.
- R9: Writes to addresses 2563 to 4095 are ignored, and reads from them return 4'b0000.
- R10: The address counter wraps from 4095 to 0 during streaming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_n | input | 1 | Port enable, active low |
| sel_data | input | 1 | 0 = address nibble, 1 = data nibble |
| wr_stb | input | 1 | Write strobe, active high |
| rd_stb | input | 1 | Read strobe, active high |
| din | input | 4 | Nibble from host |
| dout | output | 4 | Nibble to host |
| dout_oe | output | 1 | Read bus drive enable |
| cfg_rsel | output | 1 | Regulator resistor select |
| cfg_ratio | output | 3 | Divider ratio code |
| cfg_level | output | 6 | Level code |
| cfg_psrc | output | 2 | Power-source select |

## Verification
The bench builds the block with its default parameters: a 12-bit address, a 2560-nibble array and a two-stage strobe synchroniser. With these values the configuration registers sit at 2560 to 2562, and the full address range reaches 4095. Row boundaries, the last array word, the register window, the unmapped space above it and the counter wrap are therefore all reachable with real addresses. Partial address sequences that are cut off by a select fall or by a disable exercise the restart of the nibble sequence.

// File: rtl/nibram_host_port.sv
module nibram_host_port #(
  parameter int ADDR_W     = 12,
  parameter int DISP_WORDS = 2560,
  parameter int SYNC       = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_n,
  input  logic       sel_data,
  input  logic       wr_stb,
  input  logic       rd_stb,
  input  logic [3:0] din,
  output logic [3:0] dout,
  output logic       dout_oe,
  output logic       cfg_rsel,
  output logic [2:0] cfg_ratio,
  output logic [5:0] cfg_level,
  output logic [1:0] cfg_psrc
);
  localparam int NSLOT = ADDR_W / 4;
  localparam int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam int MW    = $clog2(DISP_WORDS);
  localparam logic [ADDR_W-1:0] REG0 = ADDR_W'(DISP_WORDS);
  localparam logic [ADDR_W-1:0] REG1 = ADDR_W'(DISP_WORDS + 1);
  localparam logic [ADDR_W-1:0] REG2 = ADDR_W'(DISP_WORDS + 2);

  logic [3:0]        mem [DISP_WORDS];
  logic [SYNC-1:0]   wr_sh, rd_sh;
  logic              wr_d, rd_d, sel_q;
  logic [SW-1:0]     slot;
  logic [ADDR_W-1:0] addr;
  logic [3:0]        reg0, reg1, reg2, rdq;

  wire wr_rise  = wr_sh[SYNC-1] & ~wr_d & ~en_n;
  wire rd_fall  = ~rd_sh[SYNC-1] & rd_d & ~en_n;
  wire sel_fell = sel_q & ~sel_data;
  wire [SW-1:0] base = sel_fell ? '0 : slot;
  wire in_mem   = addr < REG0;
  wire dwrite   = wr_rise & sel_data;

  assign dout      = rdq;
  assign dout_oe   = rd_stb & ~en_n;
  assign cfg_rsel  = reg0[3];
  assign cfg_ratio = reg0[2:0];
  assign cfg_level = {reg2[1:0], reg1};
  assign cfg_psrc  = reg2[3:2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_sh <= '0; rd_sh <= '0; wr_d <= 1'b0; rd_d <= 1'b0;
    end else begin
      wr_sh <= {wr_sh[SYNC-2:0], wr_stb};
      rd_sh <= {rd_sh[SYNC-2:0], rd_stb};
      wr_d  <= wr_sh[SYNC-1];
      rd_d  <= rd_sh[SYNC-1];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_q <= 1'b1;
      slot  <= '0;
      addr  <= '0;
      reg0  <= 4'b0010;
      reg1  <= 4'b0000;
      reg2  <= 4'b0000;
    end else begin
      sel_q <= sel_data;
      if (en_n)
        slot <= '0;
      else if (wr_rise && !sel_data) begin
        addr[(NSLOT-1-int'(base))*4 +: 4] <= din;
        slot <= (base == SW'(NSLOT-1)) ? '0 : base + 1'b1;
      end else if (sel_fell)
        slot <= '0;
      if (sel_data && (wr_rise || rd_fall))
        addr <= addr + 1'b1;
      if (dwrite && addr == REG0) reg0 <= din;
      if (dwrite && addr == REG1) reg1 <= din;
      if (dwrite && addr == REG2) reg2 <= din;
    end

  always_ff @(posedge clk)
    if (dwrite && in_mem) mem[addr[MW-1:0]] <= din;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)             rdq <= '0;
    else if (in_mem)        rdq <= mem[addr[MW-1:0]];
    else if (addr == REG0)  rdq <= reg0;
    else if (addr == REG1)  rdq <= reg1;
    else if (addr == REG2)  rdq <= reg2;
    else                    rdq <= '0;

  p_slot_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(slot) < NSLOT);
  p_slot_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en_n |=> slot == '0);
  p_slot_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_fell && !wr_rise) |=> slot == '0);
  p_wr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rise && sel_data) |=> addr == $past(addr) + 1'b1);
  p_rd_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fall && sel_data) |=> addr == $past(addr) + 1'b1);
  p_hold_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en_n |=> ($stable(addr) && $stable({reg0, reg1, reg2})));
  p_oe_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en_n |-> !dout_oe);
  p_reg_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dwrite |=> $stable({cfg_rsel, cfg_ratio, cfg_level, cfg_psrc}));
endmodule

// File: tb/nibram_host_port_bench.sv
module nibram_host_port_bench;
  logic clk = 1'b0, rst_n = 1'b0, en_n = 1'b0, sel_data = 1'b1;
  logic wr_stb = 1'b0, rd_stb = 1'b0;
  logic [3:0] din = '0, dout;
  logic dout_oe, cfg_rsel;
  logic [2:0] cfg_ratio;
  logic [5:0] cfg_level;
  logic [1:0] cfg_psrc;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nibram_host_port u_nibram_host_port (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .sel_data(sel_data),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .din(din), .dout(dout),
    .dout_oe(dout_oe), .cfg_rsel(cfg_rsel), .cfg_ratio(cfg_ratio),
    .cfg_level(cfg_level), .cfg_psrc(cfg_psrc));

  localparam logic [15:0] VEC [8] = '{16'h000A, 16'h01F5, 16'h020C, 16'h3E83,
                                      16'h7FFF, 16'h9E09, 16'h9FF6, 16'h0641};

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic put_nib(input logic s, input logic [3:0] d);
    @(negedge clk); sel_data = s; din = d; wr_stb = 1'b1;
    repeat (4) @(negedge clk);
    wr_stb = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic set_addr(input logic [11:0] a);
    put_nib(1'b0, a[11:8]); put_nib(1'b0, a[7:4]); put_nib(1'b0, a[3:0]);
    sel_data = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic get_nib(output logic [3:0] d, output logic oe);
    @(negedge clk); sel_data = 1'b1; rd_stb = 1'b1;
    repeat (6) @(negedge clk);
    d = dout; oe = dout_oe;
    rd_stb = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic expect_at(input string tag, input logic [11:0] a, input logic [3:0] e);
    logic [3:0] d; logic oe;
    set_addr(a);
    get_nib(d, oe);
    chk(tag, {4'h0, d}, {4'h0, e});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [3:0] d; logic oe;
    repeat (3) @(negedge clk);
    // R1 reset defaults
    chk("R1 rsel", {7'h0, cfg_rsel}, 8'h00);
    chk("R1 ratio", {5'h0, cfg_ratio}, 8'h02);
    chk("R1 level", {2'h0, cfg_level}, 8'h00);
    chk("R1 psrc", {6'h0, cfg_psrc}, 8'h00);
    chk("R1 oe", {7'h0, dout_oe}, 8'h00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4/R5 table walk over row starts and array edges
    for (int i = 0; i < 8; i++) begin
      set_addr(VEC[i][15:4]);
      put_nib(1'b1, VEC[i][3:0]);
    end
    for (int i = 0; i < 8; i++) expect_at("R5 table", VEC[i][15:4], VEC[i][3:0]);

    // R2 nibble order
    set_addr(12'h123); put_nib(1'b1, 4'h7);
    set_addr(12'h321); put_nib(1'b1, 4'h2);
    expect_at("R2 order", 12'h123, 4'h7);

    // R4/R5 streaming with auto increment, R7 oe during read
    set_addr(12'h0C8);
    put_nib(1'b1, 4'h1); put_nib(1'b1, 4'h2); put_nib(1'b1, 4'h3); put_nib(1'b1, 4'h4);
    set_addr(12'h0C8);
    for (int k = 1; k <= 4; k++) begin
      get_nib(d, oe);
      chk("R5 stream", {4'h0, d}, 8'(k));
      chk("R7 oe on", {7'h0, oe}, 8'h01);
    end
    chk("R7 oe idle", {7'h0, dout_oe}, 8'h00);

    // R3 restart on select fall
    set_addr(12'h012); put_nib(1'b1, 4'h0);
    set_addr(12'h201); put_nib(1'b1, 4'h0);
    put_nib(1'b0, 4'hF);
    sel_data = 1'b1; repeat (3) @(negedge clk);
    set_addr(12'h012); put_nib(1'b1, 4'hB);
    expect_at("R3 sel fall", 12'h012, 4'hB);
    expect_at("R3 sel fall other", 12'h201, 4'h0);

    // R3 restart on disable
    set_addr(12'h013); put_nib(1'b1, 4'h0);
    put_nib(1'b0, 4'hE);
    en_n = 1'b1; repeat (3) @(negedge clk);
    en_n = 1'b0; repeat (2) @(negedge clk);
    put_nib(1'b0, 4'h0); put_nib(1'b0, 4'h1); put_nib(1'b0, 4'h3);
    sel_data = 1'b1; repeat (2) @(negedge clk);
    put_nib(1'b1, 4'h5);
    expect_at("R3 disable", 12'h013, 4'h5);

    // R6 strobes ignored while disabled, R7 no drive
    set_addr(12'h12C); put_nib(1'b1, 4'h9);
    en_n = 1'b1;
    put_nib(1'b1, 4'h4);
    @(negedge clk); rd_stb = 1'b1; repeat (3) @(negedge clk);
    chk("R7 oe disabled", {7'h0, dout_oe}, 8'h00);
    rd_stb = 1'b0; repeat (6) @(negedge clk);
    en_n = 1'b0; repeat (2) @(negedge clk);
    put_nib(1'b1, 4'h6);
    set_addr(12'h12C);
    get_nib(d, oe); chk("R6 first", {4'h0, d}, 8'h09);
    get_nib(d, oe); chk("R6 no step", {4'h0, d}, 8'h06);

    // R8 configuration registers
    set_addr(12'hA00);
    put_nib(1'b1, 4'hD); put_nib(1'b1, 4'h6); put_nib(1'b1, 4'hB);
    chk("R8 rsel", {7'h0, cfg_rsel}, 8'h01);
    chk("R8 ratio", {5'h0, cfg_ratio}, 8'h05);
    chk("R8 level", {2'h0, cfg_level}, 8'h36);
    chk("R8 psrc", {6'h0, cfg_psrc}, 8'h02);
    set_addr(12'hA00);
    get_nib(d, oe); chk("R8 read 2560", {4'h0, d}, 8'h0D);
    get_nib(d, oe); chk("R8 read 2561", {4'h0, d}, 8'h06);
    get_nib(d, oe); chk("R8 read 2562", {4'h0, d}, 8'h0B);

    // R9 unmapped space
    set_addr(12'hA03); put_nib(1'b1, 4'h7);
    set_addr(12'hFA0); put_nib(1'b1, 4'h7);
    expect_at("R9 read 2563", 12'hA03, 4'h0);
    expect_at("R9 read 4000", 12'hFA0, 4'h0);
    chk("R9 level kept", {2'h0, cfg_level}, 8'h36);
    chk("R9 ratio kept", {5'h0, cfg_ratio}, 8'h05);

    // R10 wrap
    set_addr(12'hFFF); put_nib(1'b1, 4'h3); put_nib(1'b1, 4'h8);
    expect_at("R10 wrap", 12'h000, 4'h8);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule